// File: doc/BRIEF.md
# Page Permission Fault Checker

This block sits after address translation in a memory pipeline. For each access it takes the permission bits of the translated leaf page: readable, writable, executable and user-accessible. It also takes the kind of access, the privilege mode in effect, and a bit that lets supervisor code reach user pages. It decides whether the access may proceed. If it may not, the block reports which page-fault cause applies.

The check is combinational. The result is registered, so the response appears one cycle after a valid request and carries a one-cycle valid strobe. Atomic memory operations are checked as writes only, so they can never report a load fault. Supervisor code may never fetch instructions from a user page, even when supervisor access to user pages is enabled.

Access kind encoding on `req_kind` is: 0 fetch, 1 load, 2 load-reserved, 3 store, 4 store-conditional, 5 atomic operation. Codes 6 and 7 are treated as write-class accesses. `req_smode` is 1 for supervisor and 0 for user. The cause codes are 12 for a fetch fault, 13 for a load fault and 15 for a store fault.

Top module: `pgperm_guard`

## Requirements
- R1: A fetch (kind 0) from a page with X=0 gives fault=1 and cause 12.
- R2: A load or load-reserved (kinds 1, 2) to a page with R=0 gives fault=1 and cause 13.
- R3: A store or store-conditional (kinds 3, 4) to a page with W=0 gives fault=1 and cause 15. There is no success input, so a store-conditional is always checked.
- R4: An atomic operation (kind 5) is checked against W only. It never reports cause 13: on a page with R=0 and W=0 it reports 15, and on a page with W=1 it passes the permission check whatever R is.
- R5: In user mode an access to a page with U=0 faults with the cause of its kind, whatever R/W/X say. With U=1, only the R/W/X check applies.
- R6: A supervisor fetch from a page with U=1 faults with cause 12, whatever the supervisor-user-access bit and X are.
- R7: A supervisor data access to a page with U=1 faults with the cause of its kind when `req_sum`=0. When `req_sum`=1, only the R/W/X check applies.
- R8: A supervisor access to a page with U=0 is decided by the R/W/X check alone.
- R9: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and never otherwise. After reset, `rsp_valid`, `rsp_fault` and `rsp_cause` are 0.
- R10: When no fault is reported, including cycles with no response, `rsp_fault`=0 and `rsp_cause`=0.
- R11: Kind codes 6 and 7 are checked as write-class accesses: a fault gives cause 15 and needs W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind code |
| req_smode | input | 1 | 1 = supervisor, 0 = user |
| req_sum | input | 1 | Supervisor may reach user data pages |
| pte_r | input | 1 | Page readable |
| pte_w | input | 1 | Page writable |
| pte_x | input | 1 | Page executable |
| pte_u | input | 1 | Page user-accessible |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | CAUSE_W | Fault cause code, 0 when no fault |

## Verification
The bench sweeps every kind, mode, enable bit and permission pattern against an independent model. It pays most attention to the cases where privilege and permission interact. An atomic operation on a page that is unreadable but writable must pass; a design that also checked R would fault there, and one that classed atomics as reads would report 13. A supervisor fetch from a user page with the enable bit set must still fault; a design that applied the enable bit to fetches would let it through. Requests are sent both back to back and with gaps, so a result that leaks into an idle cycle, or a cause that is not cleared, shows up as a mismatch.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  localparam int KIND_W = 3;
  localparam logic [KIND_W-1:0] K_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] K_LOAD  = 3'd1;
  localparam logic [KIND_W-1:0] K_LR    = 3'd2;
  localparam logic [KIND_W-1:0] K_STORE = 3'd3;
  localparam logic [KIND_W-1:0] K_SC    = 3'd4;
  localparam logic [KIND_W-1:0] K_AMO   = 3'd5;

  typedef enum logic [1:0] {NEED_X = 2'd0, NEED_R = 2'd1, NEED_W = 2'd2} need_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
  } perm_t;
endpackage

// File: rtl/pgperm_rst_sync.sv
module pgperm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pgperm_class.sv
module pgperm_class
  import pgperm_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output need_e             need
);
  always_comb begin
    unique case (kind)
      K_FETCH:      need = NEED_X;
      K_LOAD, K_LR: need = NEED_R;
      default:      need = NEED_W;  // store, SC, atomic and spare codes
    endcase
  end
endmodule

// File: rtl/pgperm_decide.sv
module pgperm_decide
  import pgperm_pkg::*;
(
  input  need_e need,
  input  perm_t perm,
  input  logic  smode,
  input  logic  sum,
  output logic  fault
);
  logic bits_ok;
  logic priv_ok;

  always_comb begin
    unique case (need)
      NEED_X:  bits_ok = perm.ex;
      NEED_R:  bits_ok = perm.rd;
      default: bits_ok = perm.wr;
    endcase
  end

  always_comb begin
    if (!smode)               priv_ok = perm.usr;
    else if (!perm.usr)       priv_ok = 1'b1;
    else if (need == NEED_X)  priv_ok = 1'b0;
    else                      priv_ok = sum;
  end

  assign fault = !(bits_ok && priv_ok);
endmodule

// File: rtl/pgperm_guard.sv
module pgperm_guard
  import pgperm_pkg::*;
#(
  parameter int              CAUSE_W     = 4,
  parameter int              RST_STAGES  = 2,
  parameter logic [CAUSE_W-1:0] CODE_FETCH = 4'd12,
  parameter logic [CAUSE_W-1:0] CODE_LOAD  = 4'd13,
  parameter logic [CAUSE_W-1:0] CODE_STORE = 4'd15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic               req_smode,
  input  logic               req_sum,
  input  logic               pte_r,
  input  logic               pte_w,
  input  logic               pte_x,
  input  logic               pte_u,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause
);
  logic  srst_n;
  need_e need;
  perm_t perm;
  logic  fault_c;

  logic               valid_d, fault_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               valid_q, fault_q;
  logic [CAUSE_W-1:0] cause_q;

  pgperm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  pgperm_class u_cls (.kind(req_kind), .need(need));

  assign perm = '{rd: pte_r, wr: pte_w, ex: pte_x, usr: pte_u};

  pgperm_decide u_dec (
    .need(need), .perm(perm), .smode(req_smode), .sum(req_sum), .fault(fault_c)
  );

  // next state
  always_comb begin
    valid_d = req_valid;
    fault_d = req_valid && fault_c;
    cause_d = '0;
    if (fault_d) begin
      unique case (need)
        NEED_X:  cause_d = CODE_FETCH;
        NEED_R:  cause_d = CODE_LOAD;
        default: cause_d = CODE_STORE;
      endcase
    end
  end

  // registers; result fields load only while a request or response is live
  logic load_en;
  assign load_en = req_valid || valid_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) begin
        fault_q <= fault_d;
        cause_q <= cause_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = fault_q;
  assign rsp_cause = cause_q;
endmodule

// File: rtl/pgperm_guard_chk.sv
module pgperm_guard_chk #(
  parameter int CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0] CODE_FETCH = 4'd12,
  parameter logic [CAUSE_W-1:0] CODE_LOAD  = 4'd13,
  parameter logic [CAUSE_W-1:0] CODE_STORE = 4'd15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [2:0]         req_kind,
  input logic               req_smode,
  input logic               req_sum,
  input logic               pte_r,
  input logic               pte_w,
  input logic               pte_x,
  input logic               pte_u,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [CAUSE_W-1:0] rsp_cause
);
  a_r1_fetch_needs_x: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && !pte_x) |=> (rsp_fault && rsp_cause == CODE_FETCH));

  a_r2_load_needs_r: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd1 || req_kind == 3'd2) && !pte_r)
      |=> (rsp_fault && rsp_cause == CODE_LOAD));

  a_r3_store_needs_w: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd3 || req_kind == 3'd4) && !pte_w)
      |=> (rsp_fault && rsp_cause == CODE_STORE));

  a_r4_amo_no_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd5) |=> (rsp_cause != CODE_LOAD));

  a_r6_sup_fetch_user: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd0 && req_smode && pte_u)
      |=> (rsp_fault && rsp_cause == CODE_FETCH));

  a_r5_user_needs_u: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_smode && !pte_u) |=> rsp_fault);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r10_clean_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_cause == '0));

  a_r7_sum_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_smode && pte_u && !req_sum) |=> rsp_fault);
endmodule

bind pgperm_guard pgperm_guard_chk #(
  .CAUSE_W(CAUSE_W), .CODE_FETCH(CODE_FETCH), .CODE_LOAD(CODE_LOAD), .CODE_STORE(CODE_STORE)
) u_chk (
  .clk(clk), .rst_n(srst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_smode(req_smode), .req_sum(req_sum), .pte_r(pte_r), .pte_w(pte_w),
  .pte_x(pte_x), .pte_u(pte_u), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_cause(rsp_cause)
);

// File: tb/sim_pgperm_guard.sv
module sim_pgperm_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_smode, req_sum, pte_r, pte_w, pte_x, pte_u;
  logic [2:0] req_kind;
  logic       rsp_valid, rsp_fault;
  logic [3:0] rsp_cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit         flt;
    logic [3:0] cse;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  pgperm_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_smode(req_smode), .req_sum(req_sum), .pte_r(pte_r), .pte_w(pte_w),
    .pte_x(pte_x), .pte_u(pte_u), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  // Independent model written from the requirements
  function automatic exp_t model(input logic [2:0] k, input bit s, input bit sm,
                                 input bit r, input bit w, input bit x, input bit u);
    exp_t e;
    bit is_f, is_l, deny;
    is_f = (k == 3'd0);
    is_l = (k == 3'd1) || (k == 3'd2);
    deny = 1'b0;
    if (is_f && !x) deny = 1'b1;
    if (is_l && !r) deny = 1'b1;
    if (!is_f && !is_l && !w) deny = 1'b1;
    if (!s && !u) deny = 1'b1;
    if (s && u && is_f) deny = 1'b1;
    if (s && u && !is_f && !sm) deny = 1'b1;
    e.flt = deny;
    e.cse = !deny ? 4'd0 : is_f ? 4'd12 : is_l ? 4'd13 : 4'd15;
    if (!deny)               e.tag = (s && !u) ? "R8" : "R10";
    else if (s && u && is_f) e.tag = "R6";
    else if (!s && !u)       e.tag = "R5";
    else if (s && u)         e.tag = "R7";
    else if (is_f)           e.tag = "R1";
    else if (is_l)           e.tag = "R2";
    else if (k == 3'd5)      e.tag = "R4";
    else if (k >= 3'd6)      e.tag = "R11";
    else                     e.tag = "R3";
    return e;
  endfunction

  task automatic drive(input logic [2:0] k, input bit s, input bit sm,
                       input bit r, input bit w, input bit x, input bit u);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_smode = s; req_sum = sm;
    pte_r = r; pte_w = w; pte_x = x; pte_u = u;
    sb.push_back(model(k, s, sm, r, w, x, u));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compare at the negedge after the response register loads
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        exp_t e;
        n_chk++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R9: response with nothing expected, fault=%0d cause=%0d", rsp_fault, rsp_cause);
        end else begin
          e = sb.pop_front();
          if (rsp_fault !== e.flt || rsp_cause !== e.cse) begin
            n_bad++;
            $display("FAIL %s: fault=%0d cause=%0d expected fault=%0d cause=%0d",
                     e.tag, rsp_fault, rsp_cause, e.flt, e.cse);
          end
        end
      end else begin
        n_chk++;
        if (rsp_fault !== 1'b0 || rsp_cause !== 4'd0) begin
          n_bad++;
          $display("FAIL R10: idle fault=%0d cause=%0d expected 0/0", rsp_fault, rsp_cause);
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_smode = 1'b0; req_sum = 1'b0;
    pte_r = 1'b0; pte_w = 1'b0; pte_x = 1'b0; pte_u = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_cause !== 4'd0) begin
      n_bad++;
      $display("FAIL R9: reset outputs %0d/%0d/%0d expected 0/0/0", rsp_valid, rsp_fault, rsp_cause);
    end
    rst_n = 1'b1;
    idle(5);

    // Directed corners
    drive(3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);  // R4: AMO on W-only page passes
    drive(3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);  // R4: AMO unreadable -> 15
    drive(3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);  // R6: sup fetch user page, sum=1
    drive(3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);  // R3: SC without W
    drive(3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);  // R7: sup load user page, sum=1 passes
    idle(2);
    drive(3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);  // R11: spare code needs W
    idle(1);

    // Full sweep, back to back
    for (int k = 0; k < 8; k++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 16; p++)
          drive(3'(k), m[1], m[0], p[3], p[2], p[1], p[0]);
    idle(3);

    // Sweep with gaps
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 16; p += 3) begin
        drive(3'(k), p[0], p[1], p[3], p[2], p[1], p[0]);
        idle(1 + (p % 2));
      end
    idle(4);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule